// File: doc/BRIEF.md
# Three-Rail Core-First Power Sequencer

This block drives the enables of three external supply switches: a primary rail (H), an I/O rail (M) and a core rail (L). It takes debounced digital flags from undervoltage comparators, a primary-gate enable, two edge-triggered start inputs and a feedback comparator flag. It produces a delayed power-good flag and the three gate enables. The gate enables also serve as status bits for a register block.

The core rail always comes up before the I/O rail and goes down after it. The sequence can be timed: a rising edge on the time-mode start turns on L, and M follows after a fixed up-delay. It can also be voltage driven: a rising edge on the voltage-mode start turns on L, and M follows once the feedback flag reports that the core rail has crossed its reference. The same ordering governs rail failures and a 2-bit software shutdown code. Every delay is a parameter counted in clock cycles.

Top module: `rail_seq_ctrl`

## Requirements
- R1: During and directly after reset, with all inputs low, `ready_o`, `gate_h_o`, `gate_m_o` and `gate_l_o` are all 0.
- R2: `ready_o` rises after `PURST_CYC` consecutive clock edges that sample `uv_ok_h_i` high. It drops in the same cycle that `uv_ok_h_i` goes low.
- R3: `gate_h_o` equals `gate_h_en_i & uv_ok_h_i`, except that it is forced to 0 while bit 1 of `shdn_code_i` is set (codes 2 and 3). The output follows in the same cycle.
- R4: A rising edge on `ens_i` turns on `gate_l_o` 3 cycles after the input change, through a two-flop synchronizer and edge detection. In time mode, `gate_m_o` follows `UP_CYC` cycles after `gate_l_o`.
- R5: A falling edge on the start input that opened the sequence turns off `gate_m_o` 3 cycles after the change. `gate_l_o` turns off `DN_CYC` cycles later.
- R6: A rising edge on `setv_i` turns on `gate_l_o` 3 cycles after the change. `gate_m_o` turns on in the cycle after the first clock edge that samples `fb_above_ref_i` high while L is on; no time-out applies. A falling edge on `setv_i` follows R5.
- R7: `gate_l_o` and `gate_m_o` turn on only while `ready_o`, `uv_ok_m_i` and `uv_ok_l_i` are high. A start edge that arrives while `ready_o` is low is remembered, and L comes up one cycle after `ready_o` rises.
- R8: When `uv_ok_h_i` falls, all outputs go to 0 in the same cycle.
- R9: When `uv_ok_m_i` falls, `gate_m_o` goes off in the same cycle and `gate_l_o` follows `DN_CYC`+1 cycles later. When the M rail recovers while the request is still active, the up sequence restarts one cycle later.
- R10: When `uv_ok_l_i` falls, `gate_l_o` and `gate_m_o` go off together in the same cycle.
- R11: Shutdown code 1 turns off M at once and L `DN_CYC`+1 cycles later. Code 2 turns off only H, at once. Code 3 turns off H and M at once and L `DN_CYC`+1 cycles later.
- R12: Shutdown code 0 releases the override. H returns in the same cycle and L one cycle later, if the request is still active. M then follows the active mode.
- R13: A rising start edge detected while L is waiting out the down-delay cancels the turn-off. L stays on and the up sequence restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| uv_ok_h_i | input | 1 | Primary rail above lockout |
| uv_ok_m_i | input | 1 | I/O rail above lockout |
| uv_ok_l_i | input | 1 | Core rail above lockout |
| gate_h_en_i | input | 1 | Primary gate enable request |
| ens_i | input | 1 | Time-mode start, edge triggered, asynchronous |
| setv_i | input | 1 | Voltage-mode start, edge triggered, asynchronous |
| fb_above_ref_i | input | 1 | Core feedback above reference |
| shdn_code_i | input | 2 | Software shutdown code: 0 none, 1 M+L, 2 H, 3 all |
| ready_o | output | 1 | Delayed primary power-good |
| gate_h_o | output | 1 | Primary switch enable / status |
| gate_m_o | output | 1 | I/O switch enable / status |
| gate_l_o | output | 1 | Core switch enable / status |

## Verification
The case that is hardest to reach from the ports is a new start edge arriving while L waits out its down-delay. The edge has to land inside a window a few cycles wide, after the synchronizer latency. The stimulus gets there by dropping the time-mode start and raising it again a fixed four cycles later. The down-delay parameter is set long enough that the rising edge is detected before L would turn off, so a missing cancel shows up as L dropping. Other hard-to-reach cases are a start edge given while the primary is still out of lockout, and recovery from each rail failure and shutdown code with the request still held. Each of these is reached by holding the start input high across the fault.

// File: rtl/rail_seq_pkg.sv
`timescale 1ns/1ps
package rail_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_OFF  = 2'd0,
    SEQ_UP   = 2'd1,
    SEQ_ON   = 2'd2,
    SEQ_DOWN = 2'd3
  } seq_state_e;

  typedef enum logic {
    MODE_TIME = 1'b0,
    MODE_VOLT = 1'b1
  } seq_mode_e;
endpackage

// File: rtl/rail_seq_sync.sv
`timescale 1ns/1ps
module rail_seq_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '0;
      else         pipe_q <= {pipe_q[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/rail_seq_ready.sv
`timescale 1ns/1ps
module rail_seq_ready #(
  parameter int unsigned PURST_CYC = 1_500_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic uv_ok_i,
  output logic ready_o
);
  localparam int unsigned CNT_W = $clog2(PURST_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (!uv_ok_i) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (!rdy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(PURST_CYC - 1)) rdy_q <= 1'b1;
    end
  end

  // drop at once on primary loss
  assign ready_o = rdy_q & uv_ok_i;
endmodule

// File: rtl/rail_seq_core.sv
`timescale 1ns/1ps
module rail_seq_core
  import rail_seq_pkg::*;
#(
  parameter int unsigned UP_CYC = 93_750,
  parameter int unsigned DN_CYC = 100_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ens_s_i,
  input  logic setv_s_i,
  input  logic fb_i,
  input  logic live_i,    // ready and core rail good
  input  logic run_ok_i,  // live, I/O rail good, no M/L override
  output logic l_on_o,
  output logic m_on_o
);
  localparam int unsigned MAX_D = (UP_CYC > DN_CYC) ? UP_CYC : DN_CYC;
  localparam int unsigned CNT_W = $clog2(MAX_D + 1);

  seq_state_e       st_q, st_n;
  seq_mode_e        mode_q, mode_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             req_q, req_n;
  logic             ens_d_q, setv_d_q;
  logic             ens_rise, ens_fall, setv_rise, setv_fall, go, up_done;

  assign ens_rise  = ens_s_i & ~ens_d_q;
  assign ens_fall  = ~ens_s_i & ens_d_q;
  assign setv_rise = setv_s_i & ~setv_d_q;
  assign setv_fall = ~setv_s_i & setv_d_q;

  always_comb begin
    req_n  = req_q;
    mode_n = mode_q;
    if (ens_rise) begin
      req_n  = 1'b1;
      mode_n = MODE_TIME;
    end else if (setv_rise) begin
      req_n  = 1'b1;
      mode_n = MODE_VOLT;
    end else if ((mode_q == MODE_TIME) ? ens_fall : setv_fall) begin
      req_n = 1'b0;
    end
  end

  assign go      = req_n & run_ok_i;
  assign up_done = (mode_n == MODE_TIME) ? (cnt_q == CNT_W'(UP_CYC - 1)) : fb_i;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q + 1'b1;
    if (!live_i) begin
      st_n  = SEQ_OFF;
      cnt_n = '0;
    end else begin
      unique case (st_q)
        SEQ_OFF: begin
          cnt_n = '0;
          if (go) st_n = SEQ_UP;
        end
        SEQ_UP: begin
          if (!go) begin
            st_n  = SEQ_DOWN;
            cnt_n = '0;
          end else if (up_done) begin
            st_n  = SEQ_ON;
            cnt_n = '0;
          end
        end
        SEQ_ON: begin
          cnt_n = '0;
          if (!go) st_n = SEQ_DOWN;
        end
        SEQ_DOWN: begin
          if (go) begin        // cancel pending core turn-off
            st_n  = SEQ_UP;
            cnt_n = '0;
          end else if (cnt_q == CNT_W'(DN_CYC - 1)) begin
            st_n  = SEQ_OFF;
            cnt_n = '0;
          end
        end
        default: begin
          st_n  = SEQ_OFF;
          cnt_n = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= SEQ_OFF;
      mode_q   <= MODE_TIME;
      cnt_q    <= '0;
      req_q    <= 1'b0;
      ens_d_q  <= 1'b0;
      setv_d_q <= 1'b0;
    end else begin
      st_q     <= st_n;
      mode_q   <= mode_n;
      cnt_q    <= cnt_n;
      req_q    <= req_n;
      ens_d_q  <= ens_s_i;
      setv_d_q <= setv_s_i;
    end
  end

  assign l_on_o = (st_q != SEQ_OFF);
  assign m_on_o = (st_q == SEQ_ON);
endmodule

// File: rtl/rail_seq_ctrl.sv
`timescale 1ns/1ps
module rail_seq_ctrl #(
  parameter int unsigned PURST_CYC = 1_500_000,
  parameter int unsigned UP_CYC    = 93_750,
  parameter int unsigned DN_CYC    = 100_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       uv_ok_h_i,
  input  logic       uv_ok_m_i,
  input  logic       uv_ok_l_i,
  input  logic       gate_h_en_i,
  input  logic       ens_i,
  input  logic       setv_i,
  input  logic       fb_above_ref_i,
  input  logic [1:0] shdn_code_i,
  output logic       ready_o,
  output logic       gate_h_o,
  output logic       gate_m_o,
  output logic       gate_l_o
);
  logic [1:0] start_s;
  logic       live, run_ok, hold_ml, hold_h, l_on, m_on;

  rail_seq_sync #(.WIDTH(2), .STAGES(2)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({setv_i, ens_i}),
    .sync_o  (start_s)
  );

  rail_seq_ready #(.PURST_CYC(PURST_CYC)) i_ready (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .uv_ok_i (uv_ok_h_i),
    .ready_o (ready_o)
  );

  assign hold_ml = shdn_code_i[0];
  assign hold_h  = shdn_code_i[1];
  assign live    = ready_o & uv_ok_l_i;
  assign run_ok  = live & uv_ok_m_i & ~hold_ml;

  rail_seq_core #(.UP_CYC(UP_CYC), .DN_CYC(DN_CYC)) i_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ens_s_i  (start_s[0]),
    .setv_s_i (start_s[1]),
    .fb_i     (fb_above_ref_i),
    .live_i   (live),
    .run_ok_i (run_ok),
    .l_on_o   (l_on),
    .m_on_o   (m_on)
  );

  // failures and overrides mask outputs in the same cycle
  assign gate_h_o = gate_h_en_i & uv_ok_h_i & ~hold_h;
  assign gate_l_o = l_on & live;
  assign gate_m_o = m_on & run_ok;
endmodule

// File: rtl/rail_seq_chk.sv
`timescale 1ns/1ps
module rail_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       uv_ok_h_i,
  input logic       uv_ok_l_i,
  input logic [1:0] shdn_code_i,
  input logic       ready_o,
  input logic       gate_h_o,
  input logic       gate_m_o,
  input logic       gate_l_o
);
  assert_core_before_io_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_m_o) |-> $past(gate_l_o));

  assert_io_needs_core_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_m_o |-> gate_l_o);

  assert_primary_fail_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !uv_ok_h_i |-> !(ready_o || gate_h_o || gate_m_o || gate_l_o));

  assert_ready_after_good_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(uv_ok_h_i));

  assert_core_off_last_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(gate_l_o) && ready_o && uv_ok_l_i) |-> !$past(gate_m_o));

  assert_ready_first_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_l_o) |-> $past(ready_o));

  assert_shdn_io_off_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shdn_code_i[0] |=> (!shdn_code_i[0] || !gate_m_o));
endmodule

bind rail_seq_ctrl rail_seq_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .uv_ok_h_i   (uv_ok_h_i),
  .uv_ok_l_i   (uv_ok_l_i),
  .shdn_code_i (shdn_code_i),
  .ready_o     (ready_o),
  .gate_h_o    (gate_h_o),
  .gate_m_o    (gate_m_o),
  .gate_l_o    (gate_l_o)
);

// File: tb/test_rail_seq_ctrl.sv
`timescale 1ns/1ps
module test_rail_seq_ctrl;
  localparam int unsigned PURST = 10;
  localparam int unsigned UPD   = 5;
  localparam int unsigned DND   = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic uv_h = 0, uv_m = 0, uv_l = 0, h_en = 0, ens = 0, setv = 0, fb = 0;
  logic [1:0] shdn = 2'd0;
  logic ready, g_h, g_m, g_l;

  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;

  typedef struct {
    int         cyc;
    logic [3:0] vec;   // {ready, h, m, l}
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rail_seq_ctrl #(.PURST_CYC(PURST), .UP_CYC(UPD), .DN_CYC(DND)) i_rail_seq_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .uv_ok_h_i(uv_h), .uv_ok_m_i(uv_m), .uv_ok_l_i(uv_l),
    .gate_h_en_i(h_en), .ens_i(ens), .setv_i(setv), .fb_above_ref_i(fb),
    .shdn_code_i(shdn), .ready_o(ready), .gate_h_o(g_h), .gate_m_o(g_m), .gate_l_o(g_l)
  );

  // monitor: compare queued expectations away from the active edge
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
      exp_t e;
      e = sb_q.pop_front();
      n_chk++;
      if (e.cyc != cyc || {ready, g_h, g_m, g_l} !== e.vec) begin
        n_err++;
        $display("FAIL %s cyc %0d: actual %b expected %b (due %0d)",
                 e.tag, cyc, {ready, g_h, g_m, g_l}, e.vec, e.cyc);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic expect_at(input int delta, input logic [3:0] vec, input string tag);
    exp_t e;
    e.cyc = cyc + delta;
    e.vec = vec;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    // R1 reset
    step(); expect_at(0, 4'b0000, "R1");
    waitn(3);
    rst_ni = 1'b1; expect_at(1, 4'b0000, "R1");
    waitn(2);

    // R2/R3 primary up
    uv_h = 1; uv_m = 1; uv_l = 1; h_en = 1;
    expect_at(0, 4'b0100, "R3");
    expect_at(PURST - 1, 4'b0100, "R2");
    expect_at(PURST, 4'b1100, "R2");
    waitn(12);

    // R4 time mode up
    ens = 1;
    expect_at(2, 4'b1100, "R4");
    expect_at(3, 4'b1101, "R4");
    expect_at(3 + UPD - 1, 4'b1101, "R4");
    expect_at(3 + UPD, 4'b1111, "R4");
    waitn(10);

    // R5 time mode down
    ens = 0;
    expect_at(2, 4'b1111, "R5");
    expect_at(3, 4'b1101, "R5");
    expect_at(3 + DND - 1, 4'b1101, "R5");
    expect_at(3 + DND, 4'b1100, "R5");
    waitn(11);

    // R13 cancel of pending core turn-off
    ens = 1; expect_at(3 + UPD, 4'b1111, "R4");
    waitn(10);
    ens = 0; expect_at(3, 4'b1101, "R13");
    waitn(4);
    ens = 1;
    expect_at(5, 4'b1101, "R13");
    expect_at(3 + UPD, 4'b1111, "R13");
    waitn(10);

    // R9 I/O rail failure and recovery
    uv_m = 0;
    expect_at(0, 4'b1101, "R9");
    expect_at(DND, 4'b1101, "R9");
    expect_at(DND + 1, 4'b1100, "R9");
    waitn(9);
    uv_m = 1;
    expect_at(1, 4'b1101, "R9");
    expect_at(1 + UPD, 4'b1111, "R9");
    waitn(8);

    // R10 core rail failure
    uv_l = 0; expect_at(0, 4'b1100, "R10");
    waitn(3);
    uv_l = 1;
    expect_at(1, 4'b1101, "R10");
    expect_at(1 + UPD, 4'b1111, "R10");
    waitn(8);

    // R11 code 1, then R12 release
    shdn = 2'd1;
    expect_at(0, 4'b1101, "R11");
    expect_at(DND, 4'b1101, "R11");
    expect_at(DND + 1, 4'b1100, "R11");
    waitn(9);
    shdn = 2'd0;
    expect_at(0, 4'b1100, "R12");
    expect_at(1, 4'b1101, "R12");
    expect_at(1 + UPD, 4'b1111, "R12");
    waitn(8);

    // R11 code 2, then code 3, then release
    shdn = 2'd2; expect_at(0, 4'b1011, "R11");
    waitn(3);
    shdn = 2'd3;
    expect_at(0, 4'b1001, "R11");
    expect_at(DND + 1, 4'b1000, "R11");
    waitn(9);
    shdn = 2'd0;
    expect_at(0, 4'b1100, "R12");
    expect_at(1, 4'b1101, "R12");
    expect_at(1 + UPD, 4'b1111, "R12");
    waitn(8);

    // R3 gate-H enable input
    h_en = 0; expect_at(0, 4'b1011, "R3");
    waitn(2);
    h_en = 1; expect_at(0, 4'b1111, "R3");
    waitn(2);

    // R8 primary failure
    uv_h = 0; expect_at(0, 4'b0000, "R8");
    waitn(3);

    // R7 start edge while not ready
    ens = 0;
    waitn(5);
    ens = 1;
    expect_at(4, 4'b0000, "R7");
    expect_at(6, 4'b0000, "R7");
    waitn(8);
    uv_h = 1;
    expect_at(0, 4'b0100, "R7");
    expect_at(PURST, 4'b1100, "R2");
    expect_at(PURST + 1, 4'b1101, "R7");
    expect_at(PURST + 1 + UPD, 4'b1111, "R7");
    waitn(18);

    // R6 voltage mode
    ens = 0; expect_at(3 + DND, 4'b1100, "R5");
    waitn(11);
    fb = 0;
    setv = 1;
    expect_at(3, 4'b1101, "R6");
    expect_at(3 + UPD, 4'b1101, "R6");
    waitn(10);
    fb = 1;
    expect_at(0, 4'b1101, "R6");
    expect_at(1, 4'b1111, "R6");
    waitn(3);
    setv = 0;
    expect_at(3, 4'b1101, "R6");
    expect_at(3 + DND, 4'b1100, "R6");
    waitn(11);
    setv = 1;
    expect_at(3, 4'b1101, "R6");
    expect_at(4, 4'b1111, "R6");
    waitn(6);

    for (int i = 0; i < 50 && sb_q.size() > 0; i++) step();
    if (sb_q.size() > 0) begin
      n_chk++;
      n_err++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
    end
    finish_run();
  end
endmodule